// File: doc/BRIEF.md
# DMA Channel Transfer Sequencer

This block is the control core of a single DMA channel. It is configured in one cycle with a source address, a destination address, a 24-bit unit count and a set of mode fields. It then moves data one unit at a time. Each unit is a read request to a simple bus port followed by a write request that carries the data just read. After every unit it steps both addresses and decrements the count. At the end it either finishes normally, sets a transfer-end flag and optionally raises an interrupt, or abandons the sequence because the enables dropped or the NMI flag rose.

Three live inputs gate the channel: a channel enable, a master enable and an NMI flag. The transfer-end flag also gates it. A unit request can come from three sources. In auto mode no request is needed. Otherwise an external request line is sampled by level or by rising edge, depending on whether the channel runs in burst or cycle-steal mode and which detection was chosen. In cycle-steal mode the bus is released after every unit. In burst mode units follow back-to-back.

Top module: `dmac_seq`

## Requirements
- R1: After reset the channel is idle (busy 0, bus_req 0, te 0, end_irq 0). An idle channel leaves idle only when ch_en=1, mst_en=1, nmi=0 and te=0.
- R2: With cfg_auto=1 a started channel issues its first unit without any activity on ext_req.
- R3: Each unit is a read at the source address (bus_we=0), then a write at the destination address (bus_we=1) carrying the read data; each phase completes on bus_ack. After the write the count drops by one, and each address is stepped by its mode (0 fixed, 1 increment, 2 decrement, 3 fixed) and the unit size (cfg_usize 0=1 byte, 1=2 bytes, 2 or 3=4 bytes). bus_size shows cfg_usize.
- R4: When a unit completes with a nonzero remaining count while nmi=1, ch_en=0 or mst_en=0, the channel returns to idle with te and end_irq unchanged at 0. The same happens in the waiting state before a unit. Restoring the enables resumes from the remaining count.
- R5: When the write of the unit that brings the count to zero completes, te becomes 1 and the channel goes idle with cur_cnt 0.
- R6: end_irq is set together with te only if cfg_ie was 1 at configuration. te_clr clears both te and end_irq.
- R7: While te=1 the channel stays idle even with all enables set.
- R8: In cycle-steal mode (cfg_burst=0) bus_req drops for at least one cycle after each unit. The next unit needs ext_req high (level), unless auto mode is on.
- R9: In burst level mode (cfg_burst=1, cfg_edge=0, cfg_auto=0) units run back-to-back while ext_req is high when a unit completes. Otherwise the channel waits with bus_req low until ext_req is high.
- R10: In burst edge mode (cfg_burst=1, cfg_edge=1, cfg_auto=0) the waiting channel starts only on a rising edge of ext_req seen while waiting; a level held from before does not start it. Once started, it runs to the end regardless of ext_req.
- R11: In burst auto mode (cfg_burst=1, cfg_auto=1) all units run back-to-back with bus_req low only in the single waiting cycle after start.
- R12: A loaded count of 0 stands for 2^24 units: after the first unit cur_cnt reads 24'hFFFFFF.
- R13: cfg_load has effect only while the channel is idle; a pulse while busy changes no address, count or mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Load configuration (idle only) |
| cfg_src | input | AW | Initial source address |
| cfg_dst | input | AW | Initial destination address |
| cfg_cnt | input | CW | Unit count, 0 means 2^CW |
| cfg_smode | input | 2 | Source address mode |
| cfg_dmode | input | 2 | Destination address mode |
| cfg_usize | input | 2 | Unit size code |
| cfg_auto | input | 1 | Auto-request mode |
| cfg_burst | input | 1 | Burst mode (0 = cycle-steal) |
| cfg_edge | input | 1 | Edge detection of ext_req in burst mode |
| cfg_ie | input | 1 | End interrupt enable |
| ch_en | input | 1 | Channel enable |
| mst_en | input | 1 | Master enable |
| nmi | input | 1 | NMI flag |
| ext_req | input | 1 | External transfer request |
| te_clr | input | 1 | Clear transfer-end flag and interrupt |
| bus_req | output | 1 | Bus access request |
| bus_we | output | 1 | 1 = write phase, 0 = read phase |
| bus_addr | output | AW | Access address |
| bus_size | output | 2 | Unit size code of the access |
| bus_wdata | output | DW | Write data |
| bus_rdata | input | DW | Read data |
| bus_ack | input | 1 | Access complete |
| busy | output | 1 | Channel active |
| te | output | 1 | Transfer-end flag |
| end_irq | output | 1 | End-of-transfer interrupt request |
| cur_src | output | AW | Current source address |
| cur_dst | output | AW | Current destination address |
| cur_cnt | output | CW | Remaining unit count |

## Verification
The hardest case to reach from the ports is an abort that lands between two units of a running burst: the remaining count must be nonzero and neither te nor the interrupt may move. The stimulus gets there by slowing the bus stub to several wait cycles per phase and raising nmi in the middle of a long auto burst. It then lowers nmi and lets the same channel resume to a normal end. Edge detection is driven apart from level detection by holding ext_req high before the channel arms, then giving a single one-cycle pulse.

// File: rtl/dmac_seq_pkg.sv
package dmac_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ARM  = 2'd1,
        ST_RD   = 2'd2,
        ST_WR   = 2'd3
    } seq_st_e;

    typedef enum logic [1:0] {
        AM_FIX = 2'd0,
        AM_INC = 2'd1,
        AM_DEC = 2'd2,
        AM_RSV = 2'd3
    } amode_e;

    typedef struct packed {
        amode_e     smode;
        amode_e     dmode;
        logic [1:0] usize;
        logic       auto_req;
        logic       burst;
        logic       edge_det;
        logic       ie;
    } chcfg_t;

    function automatic logic [2:0] unit_bytes(input logic [1:0] usize);
        case (usize)
            2'd0:    return 3'd1;
            2'd1:    return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/dmac_seq_addr.sv
module dmac_seq_addr
    import dmac_seq_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  amode_e        mode,
    input  logic [1:0]    usize,
    input  logic          step,
    output logic [AW-1:0] addr
);

    logic [AW-1:0] addr_q;
    logic [AW-1:0] inc;
    logic [AW-1:0] nxt;

    always_comb begin
        inc = AW'(unit_bytes(usize));
        case (mode)
            AM_INC:  nxt = addr_q + inc;
            AM_DEC:  nxt = addr_q - inc;
            default: nxt = addr_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)       addr_q <= '0;
        else if (load) addr_q <= load_val;
        else if (step) addr_q <= nxt;
    end

    assign addr = addr_q;

    // R3
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && (!step || mode == AM_FIX || mode == AM_RSV)) |=> $stable(addr_q));

endmodule

// File: rtl/dmac_seq_reqdet.sv
module dmac_seq_reqdet (
    input  logic clk,
    input  logic rst,
    input  logic req,
    input  logic edge_mode,
    output logic hit
);

    logic prev_q;
    logic rise;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= req;
    end

    assign rise = req & ~prev_q;
    assign hit  = edge_mode ? rise : req;

    // R10
    rise_once_chk: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);

endmodule

// File: rtl/dmac_seq.sv
module dmac_seq
    import dmac_seq_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int CW = 24
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_load,
    input  logic [AW-1:0] cfg_src,
    input  logic [AW-1:0] cfg_dst,
    input  logic [CW-1:0] cfg_cnt,
    input  logic [1:0]    cfg_smode,
    input  logic [1:0]    cfg_dmode,
    input  logic [1:0]    cfg_usize,
    input  logic          cfg_auto,
    input  logic          cfg_burst,
    input  logic          cfg_edge,
    input  logic          cfg_ie,
    input  logic          ch_en,
    input  logic          mst_en,
    input  logic          nmi,
    input  logic          ext_req,
    input  logic          te_clr,
    output logic          bus_req,
    output logic          bus_we,
    output logic [AW-1:0] bus_addr,
    output logic [1:0]    bus_size,
    output logic [DW-1:0] bus_wdata,
    input  logic [DW-1:0] bus_rdata,
    input  logic          bus_ack,
    output logic          busy,
    output logic          te,
    output logic          end_irq,
    output logic [AW-1:0] cur_src,
    output logic [AW-1:0] cur_dst,
    output logic [CW-1:0] cur_cnt
);

    localparam logic [CW-1:0] CNT_ONE = CW'(1);

    seq_st_e       st_q, st_d;
    chcfg_t        cfg_q;
    logic [CW-1:0] cnt_q;
    logic [DW-1:0] data_q;
    logic          te_q, irq_q;

    logic idle, ld, run_ok, halt, unit_done, last;
    logic edge_mode, req_hit, go, more;

    assign idle      = (st_q == ST_IDLE);
    assign ld        = cfg_load & idle;
    assign run_ok    = ch_en & mst_en & ~nmi;
    assign halt      = ~run_ok;
    assign unit_done = (st_q == ST_WR) & bus_ack;
    assign last      = (cnt_q == CNT_ONE);
    assign edge_mode = cfg_q.burst & cfg_q.edge_det & ~cfg_q.auto_req;
    assign go        = cfg_q.auto_req | req_hit;
    assign more      = cfg_q.burst & (cfg_q.auto_req | edge_mode | ext_req);

    dmac_seq_reqdet u_req (
        .clk       (clk),
        .rst       (rst),
        .req       (ext_req),
        .edge_mode (edge_mode),
        .hit       (req_hit)
    );

    dmac_seq_addr #(.AW(AW)) u_src (
        .clk      (clk),
        .rst      (rst),
        .load     (ld),
        .load_val (cfg_src),
        .mode     (cfg_q.smode),
        .usize    (cfg_q.usize),
        .step     (unit_done),
        .addr     (cur_src)
    );

    dmac_seq_addr #(.AW(AW)) u_dst (
        .clk      (clk),
        .rst      (rst),
        .load     (ld),
        .load_val (cfg_dst),
        .mode     (cfg_q.dmode),
        .usize    (cfg_q.usize),
        .step     (unit_done),
        .addr     (cur_dst)
    );

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (run_ok && !te_q) st_d = ST_ARM;
            ST_ARM: begin
                if (halt)    st_d = ST_IDLE;
                else if (go) st_d = ST_RD;
            end
            ST_RD: if (bus_ack) st_d = ST_WR;
            ST_WR: begin
                if (bus_ack) begin
                    if (last || halt) st_d = ST_IDLE;
                    else if (more)    st_d = ST_RD;
                    else              st_d = ST_ARM;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            cfg_q  <= '0;
            cnt_q  <= '0;
            data_q <= '0;
            te_q   <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            st_q <= st_d;
            if (ld) begin
                cfg_q.smode    <= amode_e'(cfg_smode);
                cfg_q.dmode    <= amode_e'(cfg_dmode);
                cfg_q.usize    <= cfg_usize;
                cfg_q.auto_req <= cfg_auto;
                cfg_q.burst    <= cfg_burst;
                cfg_q.edge_det <= cfg_edge;
                cfg_q.ie       <= cfg_ie;
                cnt_q          <= cfg_cnt;
            end else if (unit_done) begin
                cnt_q <= cnt_q - CNT_ONE;
            end
            if (st_q == ST_RD && bus_ack) data_q <= bus_rdata;
            if (unit_done && last) begin
                te_q  <= 1'b1;
                irq_q <= cfg_q.ie;
            end else if (te_clr) begin
                te_q  <= 1'b0;
                irq_q <= 1'b0;
            end
        end
    end

    assign bus_req   = (st_q == ST_RD) | (st_q == ST_WR);
    assign bus_we    = (st_q == ST_WR);
    assign bus_addr  = (st_q == ST_WR) ? cur_dst : cur_src;
    assign bus_size  = cfg_q.usize;
    assign bus_wdata = data_q;
    assign busy      = ~idle;
    assign te        = te_q;
    assign end_irq   = irq_q;
    assign cur_cnt   = cnt_q;

    // R1
    start_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_IDLE && !(run_ok && !te_q)) |=> (st_q == ST_IDLE));

    // R4
    abort_chk: assert property (@(posedge clk) disable iff (rst)
        (unit_done && !last && halt) |=> (st_q == ST_IDLE && !te_q));

    // R5
    te_set_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(te_q) |-> $past(unit_done && last));

    // R6
    irq_te_chk: assert property (@(posedge clk) disable iff (rst)
        irq_q |-> te_q);

    // R8
    cs_release_chk: assert property (@(posedge clk) disable iff (rst)
        (unit_done && !cfg_q.burst) |=> !bus_req);

    // R13
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q != ST_IDLE) |=> $stable(cfg_q));

endmodule

// File: tb/sim_dmac_seq.sv
module sim_dmac_seq;

    localparam logic [31:0] RD_XOR = 32'hC3A5_0F1E;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst;
    logic        cfg_load;
    logic [31:0] cfg_src, cfg_dst;
    logic [23:0] cfg_cnt;
    logic [1:0]  cfg_smode, cfg_dmode, cfg_usize;
    logic        cfg_auto, cfg_burst, cfg_edge, cfg_ie;
    logic        ch_en, mst_en, nmi, ext_req, te_clr;
    logic        bus_req, bus_we, bus_ack;
    logic [31:0] bus_addr, bus_wdata, bus_rdata;
    logic [1:0]  bus_size;
    logic        busy, te, end_irq;
    logic [31:0] cur_src, cur_dst;
    logic [23:0] cur_cnt;

    assign bus_rdata = bus_addr ^ RD_XOR;

    dmac_seq u0 (
        .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_src(cfg_src), .cfg_dst(cfg_dst),
        .cfg_cnt(cfg_cnt), .cfg_smode(cfg_smode), .cfg_dmode(cfg_dmode), .cfg_usize(cfg_usize),
        .cfg_auto(cfg_auto), .cfg_burst(cfg_burst), .cfg_edge(cfg_edge), .cfg_ie(cfg_ie),
        .ch_en(ch_en), .mst_en(mst_en), .nmi(nmi), .ext_req(ext_req), .te_clr(te_clr),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_size(bus_size),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack), .busy(busy),
        .te(te), .end_irq(end_irq), .cur_src(cur_src), .cur_dst(cur_dst), .cur_cnt(cur_cnt)
    );

    int checks = 0;
    int errors = 0;
    int gaps   = 0;
    int ack_wait = 0;
    int wcnt   = 0;
    int cyc    = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // bus stub: acknowledges each phase after ack_wait stall cycles
    always @(negedge clk) begin
        if (rst || !bus_req) begin
            wcnt = 0;
            bus_ack = 1'b0;
        end else begin
            bus_ack = (wcnt >= ack_wait);
            wcnt = bus_ack ? 0 : wcnt + 1;
        end
    end

    // reference model
    int          m_st;
    logic [31:0] m_src, m_dst, m_data;
    logic [23:0] m_cnt;
    logic        m_te, m_irq, m_prev, m_halt, m_rise, m_end;
    logic [1:0]  m_sm, m_dm, m_sz;
    logic        m_auto, m_burst, m_edge, m_ie;

    function automatic logic [31:0] mstep(input logic [31:0] a, input logic [1:0] mode,
                                          input logic [1:0] sz);
        int b;
        b = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
        if (mode == 2'd1) return a + b;
        if (mode == 2'd2) return a - b;
        return a;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_st = 0; m_src = 0; m_dst = 0; m_data = 0; m_cnt = 0;
            m_te = 0; m_irq = 0; m_prev = 0;
            m_sm = 0; m_dm = 0; m_sz = 0; m_auto = 0; m_burst = 0; m_edge = 0; m_ie = 0;
        end else begin
            m_halt = !(ch_en && mst_en && !nmi);
            m_rise = ext_req && !m_prev;
            m_prev = ext_req;
            m_end  = 0;
            case (m_st)
                0: begin
                    if (cfg_load) begin
                        m_src = cfg_src; m_dst = cfg_dst; m_cnt = cfg_cnt;
                        m_sm = cfg_smode; m_dm = cfg_dmode; m_sz = cfg_usize;
                        m_auto = cfg_auto; m_burst = cfg_burst; m_edge = cfg_edge; m_ie = cfg_ie;
                    end
                    if (!m_halt && !m_te) m_st = 1;
                end
                1: begin
                    if (m_halt) m_st = 0;
                    else if (m_auto || ((m_burst && m_edge) ? m_rise : ext_req)) m_st = 2;
                end
                2: if (bus_ack) begin m_data = m_src ^ RD_XOR; m_st = 3; end
                default: if (bus_ack) begin
                    m_src = mstep(m_src, m_sm, m_sz);
                    m_dst = mstep(m_dst, m_dm, m_sz);
                    if (m_cnt == 24'd1) begin m_end = 1; m_st = 0; end
                    else if (m_halt) m_st = 0;
                    else if (m_burst && (m_auto || m_edge || ext_req)) m_st = 2;
                    else m_st = 1;
                    m_cnt = m_cnt - 24'd1;
                end
            endcase
            if (m_end) begin m_te = 1; m_irq = m_ie; end
            else if (te_clr) begin m_te = 0; m_irq = 0; end
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst) begin
            chk("R3 bus_req", bus_req, m_st >= 2);
            chk("R3 bus_we", bus_we, m_st == 3);
            if (m_st >= 2) chk("R3 bus_addr", bus_addr, (m_st == 2) ? m_src : m_dst);
            if (m_st == 3) chk("R3 bus_wdata", bus_wdata, m_data);
            if (m_st >= 2) chk("R3 bus_size", bus_size, m_sz);
            chk("R1 busy", busy, m_st != 0);
            chk("R5 te", te, m_te);
            chk("R6 end_irq", end_irq, m_irq);
            chk("R3 cur_cnt", cur_cnt, m_cnt);
            chk("R3 cur_src", cur_src, m_src);
            chk("R3 cur_dst", cur_dst, m_dst);
            if (busy && !bus_req) gaps++;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL R1 watchdog actual=%0d expected<%0d", cyc, 150000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic load(input logic [31:0] s, input logic [31:0] d, input logic [23:0] c,
                        input logic [1:0] sm, input logic [1:0] dm, input logic [1:0] sz,
                        input logic au, input logic bu, input logic ed, input logic ie);
        @(negedge clk);
        cfg_src = s; cfg_dst = d; cfg_cnt = c; cfg_smode = sm; cfg_dmode = dm;
        cfg_usize = sz; cfg_auto = au; cfg_burst = bu; cfg_edge = ed; cfg_ie = ie;
        cfg_load = 1;
        @(negedge clk);
        cfg_load = 0;
    endtask

    task automatic run_until_idle(input int limit);
        int n = 0;
        @(negedge clk);
        while (busy && n < limit) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic clear_end();
        ch_en = 0;
        @(negedge clk);
        te_clr = 1;
        @(negedge clk);
        te_clr = 0;
    endtask

    initial begin
        rst = 1; cfg_load = 0; cfg_src = 0; cfg_dst = 0; cfg_cnt = 0;
        cfg_smode = 0; cfg_dmode = 0; cfg_usize = 0; cfg_auto = 0; cfg_burst = 0;
        cfg_edge = 0; cfg_ie = 0; ch_en = 0; mst_en = 1; nmi = 0; ext_req = 0; te_clr = 0;
        bus_ack = 0;
        tick(3);
        rst = 0;
        @(negedge clk);
        chk("R1 reset busy", busy, 0);
        chk("R1 reset bus_req", bus_req, 0);
        chk("R1 reset te", te, 0);
        chk("R1 reset end_irq", end_irq, 0);

        // auto, cycle-steal, word units, increment both
        load(32'h1000, 32'h2000, 24'd3, 2'd1, 2'd1, 2'd2, 1, 0, 0, 1);
        ack_wait = 1;
        tick(4);
        chk("R1 no start without channel enable", busy, 0);
        gaps = 0;
        ch_en = 1;
        run_until_idle(500);
        chk("R2 auto mode completes without ext_req", te, 1);
        chk("R8 bus released before each unit", gaps, 3);
        chk("R3 source incremented by 4 per unit", cur_src, 32'h100C);
        chk("R3 destination incremented", cur_dst, 32'h200C);
        chk("R5 count reaches zero", cur_cnt, 0);
        chk("R6 interrupt raised with enable", end_irq, 1);
        tick(5);
        chk("R7 te blocks restart", busy, 0);
        clear_end();
        chk("R6 te_clr clears interrupt", end_irq, 0);
        chk("R6 te_clr clears te", te, 0);

        // burst level external, decrement source, fixed destination, half-words
        load(32'h3000, 32'h4000, 24'd6, 2'd2, 2'd0, 2'd1, 0, 1, 0, 0);
        ack_wait = 0;
        ch_en = 1;
        tick(3);
        chk("R9 waits for request", {busy, bus_req}, 2'b10);
        ext_req = 1;
        tick(4);
        ext_req = 0;
        tick(6);
        chk("R9 stalls when request drops", {busy, bus_req}, 2'b10);
        ext_req = 1;
        run_until_idle(500);
        ext_req = 0;
        chk("R9 completes", te, 1);
        chk("R6 no interrupt without enable", end_irq, 0);
        chk("R3 source decremented by 2 per unit", cur_src, 32'h2FF4);
        chk("R3 destination fixed", cur_dst, 32'h4000);
        clear_end();

        // burst edge, byte units
        load(32'h5000, 32'h6000, 24'd4, 2'd1, 2'd1, 2'd0, 0, 1, 1, 1);
        ext_req = 1;
        ch_en = 1;
        tick(5);
        chk("R10 held level does not start", {busy, bus_req}, 2'b10);
        ext_req = 0;
        tick(1);
        ext_req = 1;
        tick(1);
        ext_req = 0;
        run_until_idle(500);
        chk("R10 one edge runs to end", te, 1);
        chk("R10 byte stepping", cur_dst, 32'h6004);
        clear_end();

        // burst auto with slow bus, NMI abort mid-sequence, load while busy
        load(32'h7000, 32'h8000, 24'd10, 2'd1, 2'd1, 2'd2, 1, 1, 0, 1);
        ack_wait = 2;
        gaps = 0;
        ch_en = 1;
        tick(8);
        cfg_src = 32'hDEAD_0000; cfg_cnt = 24'd99; cfg_smode = 2'd0; cfg_load = 1;
        tick(1);
        cfg_load = 0;
        nmi = 1;
        run_until_idle(500);
        chk("R4 abort leaves te clear", te, 0);
        chk("R4 abort raises no interrupt", end_irq, 0);
        chk("R4 abort leaves partial count", (cur_cnt > 0 && cur_cnt < 10), 1);
        chk("R11 burst holds bus until abort", gaps, 1);
        nmi = 0;
        gaps = 0;
        run_until_idle(1000);
        chk("R4 resume reaches normal end", te, 1);
        chk("R11 burst holds bus after resume", gaps, 1);
        chk("R13 load while busy ignored", cur_src, 32'h7028);
        chk("R5 count zero after resume", cur_cnt, 0);
        clear_end();

        // zero count means maximum, master enable abort
        load(32'h9000, 32'hA000, 24'd0, 2'd0, 2'd0, 2'd0, 1, 1, 0, 0);
        ack_wait = 0;
        ch_en = 1;
        tick(6);
        mst_en = 0;
        run_until_idle(500);
        chk("R12 zero count is maximum", cur_cnt[23:16], 8'hFF);
        chk("R4 master enable abort", te, 0);
        ch_en = 0;
        tick(1);
        mst_en = 1;
        tick(3);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule